// File: doc/BRIEF.md
# 8-bit Timer/Counter with One Compare Channel

An 8-bit count register advances on timer ticks taken from a shared prescaler. A 3-bit clock select chooses the tick rate from the system clock. One clock-select setting stops the count. A mode field picks the counting sequence: a free-running up count that wraps, an up count that clears after a compare match, or an up/down phase-correct sweep that turns at the top and at the bottom. A single compare register is checked against the count on every cycle. A match drives a waveform pin and sets a compare flag. The overflow point depends on the mode, and it sets an overflow flag. Each flag can raise an interrupt request, gated by its own enable and a global enable input.

Software works through a small register bus: a write strobe, a 2-bit address, write data, and a read path that answers in the same cycle. The count can be read or written at any time. A write to the count takes effect even when a tick arrives in that cycle. Flags clear when software writes a one to them, or when the matching interrupt is acknowledged.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset every register reads 0x00, wave_o is 0, and both interrupt requests are low.
- R2: With clock select 0, 6 or 7, no tick occurs and the count holds its value.
- R3: Clock select 1, 2, 3, 4 and 5 gives one tick every 1, 8, 64, 256 and 1024 system clocks. Over any window of 10 periods the count advances by exactly 10.
- R4: Mode 0 (and reserved mode 3) counts up on each tick and wraps from 0xFF to 0x00. The tick that wraps sets the overflow flag (flag register bit 0).
- R5: In mode 1, a tick taken while the count equals the compare value loads zero instead of incrementing.
- R6: Mode 2 counts up to 0xFF, then down to 0x00, then up again. A tick at 0x00 while counting down sets the overflow flag.
- R7: The compare flag (flag register bit 1) sets on the first tick taken while count equals compare. It does not set in the cycle where equality first appears, and it never sets while the timer is stopped.
- R8: A write to the count (address 0) loads the written value even when a tick falls in the same cycle. That tick has no effect.
- R9: Writing a one to flag bit 0 or bit 1 clears that flag, and writing a zero leaves it as it is. Pulsing ovf_ack_i or cmp_ack_i clears the matching flag.
- R10: irq_ovf_o and irq_cmp_o are high only when their flag is set, the enable is set (flag register bits 4 and 5), and gie_i is high.
- R11: Control bits [6:5] select the pin action on a match tick outside mode 2: 00 forces wave_o low, 01 toggles, 10 clears, 11 sets.
- R12: In mode 2 with pin action not 00, a match tick while counting up clears the pin, and one while counting down sets it.
- R13: Address map. 0 is the count, 1 is compare, and 2 is control ([2:0] clock select, [4:3] mode, [6:5] pin action). 3 holds the flags and enables. Reads return the stored values at any time, whether the timer is running or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| gie_i | input | 1 | Global interrupt enable |
| ovf_ack_i | input | 1 | Overflow interrupt acknowledge |
| cmp_ack_i | input | 1 | Compare interrupt acknowledge |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cmp_o | output | 1 | Compare interrupt request |
| wave_o | output | 1 | Compare waveform output |

## Verification
Register writes land on the rising edge where the strobe is sampled. The count, flags and pin change on the same edge as the tick that moves them, and reads are combinational. The bench therefore drives at the falling edge and samples one nanosecond after the next falling edge. A run that starts with a control write at edge E0 and stops with a second control write at edge EN covers exactly N ticks at divide-by-1. Each vector's expected count, flags and pin follow from that. The compare-flag delay is checked by sampling in the cycle before the first tick, when count already equals compare, and again after it. Prescaler rates are checked over windows that hold a whole number of periods, so the phase of the free-running divider does not matter.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP = 2'b00,
    MODE_CTC  = 2'b01,
    MODE_PC   = 2'b10,
    MODE_RSV  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    PIN_OFF = 2'b00,
    PIN_TGL = 2'b01,
    PIN_CLR = 2'b10,
    PIN_SET = 2'b11
  } pin_e;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  localparam int NUM_DIV = 5;
  localparam int DIV_LOG2 [NUM_DIV] = '{0, 3, 6, 8, 10};
endpackage

// File: rtl/tmr8_presc.sv
module tmr8_presc
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10,
  parameter int CS_W  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CS_W-1:0] cs_i,
  output logic            tick_o
);
  logic [PRE_W-1:0]   div_q;
  logic [NUM_DIV-1:0] stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
    if (DIV_LOG2[k] == 0) begin : g_full
      assign stb[k] = 1'b1;
    end else begin : g_div
      assign stb[k] = &div_q[DIV_LOG2[k]-1:0];
    end
  end

  always_comb begin
    tick_o = 1'b0;
    for (int k = 0; k < NUM_DIV; k++) begin
      if (int'(cs_i) == k + 1) tick_o = stb[k];
    end
  end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  mode_e        mode_i,
  input  logic [W-1:0] ocr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         ovf_evt_o,
  output logic         cmp_evt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d;
  logic         step, at_top, at_bot, match;

  // write to the count swallows the tick of that cycle
  assign step   = tick_i & ~wr_i;
  assign at_top = (cnt_q == CNT_MAX);
  assign at_bot = (cnt_q == '0);
  assign match  = (cnt_q == ocr_i);

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    down_d = 1'b0;
    unique case (mode_i)
      MODE_CTC: cnt_d = match ? '0 : cnt_q + 1'b1;
      MODE_PC: begin
        if (!down_q) begin
          down_d = at_top;
          cnt_d  = at_top ? cnt_q - 1'b1 : cnt_q + 1'b1;
        end else begin
          down_d = ~at_bot;
          cnt_d  = at_bot ? cnt_q + 1'b1 : cnt_q - 1'b1;
        end
      end
      default: cnt_d = cnt_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      if (wr_i)      cnt_q <= wdata_i;
      else if (step) cnt_q <= cnt_d;
      if (mode_i != MODE_PC) down_q <= 1'b0;
      else if (step)         down_q <= down_d;
    end
  end

  assign ovf_evt_o = step & ((mode_i == MODE_PC) ? (at_bot & down_q) : at_top);
  assign cmp_evt_o = step & match;
  assign cnt_o     = cnt_q;
  assign down_o    = down_q;
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  evt_i,
  input  mode_e mode_i,
  input  pin_e  act_i,
  input  logic  down_i,
  output logic  wave_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (evt_i && act_i != PIN_OFF) begin
      if (mode_i == MODE_PC) begin
        pin_q <= down_i;
      end else begin
        unique case (act_i)
          PIN_TGL: pin_q <= ~pin_q;
          PIN_CLR: pin_q <= 1'b0;
          PIN_SET: pin_q <= 1'b1;
          default: pin_q <= pin_q;
        endcase
      end
    end
  end

  assign wave_o = (act_i != PIN_OFF) & pin_q;
endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10,
  parameter int CS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             gie_i,
  input  logic             ovf_ack_i,
  input  logic             cmp_ack_i,
  output logic             irq_ovf_o,
  output logic             irq_cmp_o,
  output logic             wave_o
);
  logic [CNT_W-1:0] ocr_q, cnt;
  logic [CS_W-1:0]  cs_q;
  mode_e            mode_q;
  pin_e             act_q;
  logic             ovf_ie_q, cmp_ie_q, ovf_flag_q, cmp_flag_q;
  logic             tick, down, ovf_evt, cmp_evt;
  logic             wr_cnt, wr_cmp, wr_ctrl, wr_flag;
  logic             ovf_clr, cmp_clr;

  assign wr_cnt  = reg_wr_i && reg_addr_i == ADDR_CNT;
  assign wr_cmp  = reg_wr_i && reg_addr_i == ADDR_CMP;
  assign wr_ctrl = reg_wr_i && reg_addr_i == ADDR_CTRL;
  assign wr_flag = reg_wr_i && reg_addr_i == ADDR_FLAG;
  assign ovf_clr = ovf_ack_i | (wr_flag & reg_wdata_i[0]);
  assign cmp_clr = cmp_ack_i | (wr_flag & reg_wdata_i[1]);

  tmr8_presc #(.PRE_W(PRE_W), .CS_W(CS_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_i  (cs_q),
    .tick_o(tick)
  );

  tmr8_core #(.W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .mode_i   (mode_q),
    .ocr_i    (ocr_q),
    .wr_i     (wr_cnt),
    .wdata_i  (reg_wdata_i),
    .cnt_o    (cnt),
    .down_o   (down),
    .ovf_evt_o(ovf_evt),
    .cmp_evt_o(cmp_evt)
  );

  tmr8_wave u_wave (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (cmp_evt),
    .mode_i(mode_q),
    .act_i (act_q),
    .down_i(down),
    .wave_o(wave_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_q    <= '0;
      cs_q     <= '0;
      mode_q   <= MODE_WRAP;
      act_q    <= PIN_OFF;
      ovf_ie_q <= 1'b0;
      cmp_ie_q <= 1'b0;
    end else begin
      if (wr_cmp) ocr_q <= reg_wdata_i;
      if (wr_ctrl) begin
        cs_q   <= reg_wdata_i[CS_W-1:0];
        mode_q <= mode_e'(reg_wdata_i[4:3]);
        act_q  <= pin_e'(reg_wdata_i[6:5]);
      end
      if (wr_flag) begin
        ovf_ie_q <= reg_wdata_i[4];
        cmp_ie_q <= reg_wdata_i[5];
      end
    end
  end

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_flag_q <= 1'b0;
      cmp_flag_q <= 1'b0;
    end else begin
      if (ovf_evt)      ovf_flag_q <= 1'b1;
      else if (ovf_clr) ovf_flag_q <= 1'b0;
      if (cmp_evt)      cmp_flag_q <= 1'b1;
      else if (cmp_clr) cmp_flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CNT: reg_rdata_o = cnt;
      ADDR_CMP: reg_rdata_o = ocr_q;
      ADDR_CTRL: begin
        reg_rdata_o[CS_W-1:0] = cs_q;
        reg_rdata_o[4:3]      = mode_q;
        reg_rdata_o[6:5]      = act_q;
      end
      default: begin
        reg_rdata_o[0] = ovf_flag_q;
        reg_rdata_o[1] = cmp_flag_q;
        reg_rdata_o[4] = ovf_ie_q;
        reg_rdata_o[5] = cmp_ie_q;
      end
    endcase
  end

  assign irq_ovf_o = ovf_flag_q & ovf_ie_q & gie_i;
  assign irq_cmp_o = cmp_flag_q & cmp_ie_q & gie_i;
endmodule

// File: rtl/tmr8_cmp_chk.sv
module tmr8_cmp_chk #(
  parameter int W    = 8,
  parameter int CS_W = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         reg_wr_i,
  input logic [1:0]   reg_addr_i,
  input logic [W-1:0] reg_wdata_i,
  input logic         gie_i,
  input logic         cmp_ack_i,
  input logic         irq_ovf_o,
  input logic         irq_cmp_o,
  input logic [W-1:0] cnt,
  input logic [W-1:0] ocr,
  input logic [CS_W-1:0] cs,
  input logic [1:0]   mode,
  input logic         tick,
  input logic         cmp_flag
);
  logic wr_cnt;
  assign wr_cnt = reg_wr_i && reg_addr_i == 2'd0;

  AST_CNT_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> cnt == $past(reg_wdata_i)); // R8

  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs == 0 || cs > 5) && !wr_cnt |=> $stable(cnt)); // R2

  AST_CTC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !wr_cnt && mode == 2'b01 && cnt == ocr |=> cnt == '0); // R5

  AST_PC_TURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !wr_cnt && mode == 2'b10 && cnt == '1 |=> cnt == {{(W-1){1'b1}}, 1'b0}); // R6

  AST_CMP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_flag) |-> $past(tick && cnt == ocr)); // R7

  AST_CMP_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_ack_i && !(tick && cnt == ocr) |=> !cmp_flag); // R9

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_ovf_o && !irq_cmp_o); // R10
endmodule

bind tmr8_cmp tmr8_cmp_chk #(.W(CNT_W), .CS_W(CS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .gie_i      (gie_i),
  .cmp_ack_i  (cmp_ack_i),
  .irq_ovf_o  (irq_ovf_o),
  .irq_cmp_o  (irq_cmp_o),
  .cnt        (cnt),
  .ocr        (ocr_q),
  .cs         (cs_q),
  .mode       (mode_q),
  .tick       (tick),
  .cmp_flag   (cmp_flag_q)
);

// File: tb/tmr8_cmp_test.sv
module tmr8_cmp_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       gie_i = 1'b0;
  logic       ovf_ack_i = 1'b0;
  logic       cmp_ack_i = 1'b0;
  logic       irq_ovf_o, irq_cmp_o, wave_o;

  int n_run = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  tmr8_cmp uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .gie_i      (gie_i),
    .ovf_ack_i  (ovf_ack_i),
    .cmp_ack_i  (cmp_ack_i),
    .irq_ovf_o  (irq_ovf_o),
    .irq_cmp_o  (irq_cmp_o),
    .wave_o     (wave_o)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  act;
    logic [7:0]  ocr;
    logic [7:0]  start;
    logic [15:0] n;
    logic [7:0]  e_cnt;
    logic        e_ovf;
    logic        e_cmp;
    logic        e_wave;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 8'h05, 8'h03, 16'd4,   8'h07, 1'b0, 1'b1, 1'b1}, // R4 R11 toggle
    '{2'd0, 2'd3, 8'hFF, 8'hFD, 16'd4,   8'h01, 1'b1, 1'b1, 1'b1}, // R4 wrap, R11 set
    '{2'd0, 2'd0, 8'h10, 8'hF0, 16'd3,   8'hF3, 1'b0, 1'b0, 1'b0}, // R4 no match, R11 off
    '{2'd1, 2'd1, 8'h04, 8'h02, 16'd5,   8'h02, 1'b0, 1'b1, 1'b1}, // R5
    '{2'd1, 2'd1, 8'h03, 8'h00, 16'd8,   8'h00, 1'b0, 1'b1, 1'b0}, // R5 two periods
    '{2'd2, 2'd2, 8'hFE, 8'hFD, 16'd4,   8'hFD, 1'b0, 1'b1, 1'b1}, // R6 top turn, R12
    '{2'd2, 2'd2, 8'h01, 8'hFF, 16'd256, 8'h01, 1'b1, 1'b1, 1'b1}, // R6 bottom, R12 set down
    '{2'd2, 2'd2, 8'h01, 8'hFF, 16'd257, 8'h02, 1'b1, 1'b1, 1'b0}, // R6, R12 clear up
    '{2'd3, 2'd1, 8'h00, 8'hFE, 16'd3,   8'h01, 1'b1, 1'b1, 1'b1}  // R4 reserved mode
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1;
    reg_addr_i = a;
    reg_wdata_i = d;
    @(posedge clk_i);
    #1 reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // run with control word run_w for n ticks at divide-by-1, then store stop_w
  task automatic run_n(input logic [7:0] run_w, input logic [7:0] stop_w, input int n);
    wr(2'd2, run_w);
    repeat (n - 1) @(posedge clk_i);
    wr(2'd2, stop_w);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] ctl;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd1, VECS[i].ocr);
      wr(2'd0, VECS[i].start);
      ctl = {1'b0, VECS[i].act, VECS[i].mode, 3'd1};
      run_n(ctl, {ctl[7:3], 3'd0}, int'(VECS[i].n));
      rd(2'd0, d);
      chk($sformatf("R4/R5/R6 vec%0d count", i), d, VECS[i].e_cnt);
      rd(2'd3, d);
      chk($sformatf("R4/R6/R7 vec%0d flags", i), d, {6'd0, VECS[i].e_cmp, VECS[i].e_ovf});
      chk($sformatf("R11/R12 vec%0d wave", i), {7'd0, wave_o}, {7'd0, VECS[i].e_wave});
    end

    // R1 reset state
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R1 reg after reset", d, 8'h00);
    end
    chk("R1 wave after reset", {7'd0, wave_o}, 8'h00);
    chk("R1 irq after reset", {6'd0, irq_ovf_o, irq_cmp_o}, 8'h00);

    // R2 stopped selects hold the count
    foreach (ctl[j]) begin end
    for (int s = 0; s < 8; s += 1) begin
      if (s != 0 && s != 6 && s != 7) continue;
      wr(2'd0, 8'h55);
      wr(2'd2, s[7:0]);
      repeat (20) @(posedge clk_i);
      rd(2'd0, d);
      chk($sformatf("R2 stopped cs=%0d", s), d, 8'h55);
    end

    // R3 divider rates: 10 periods per window
    for (int s = 1; s <= 5; s++) begin
      int per;
      per = (s == 1) ? 1 : (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h00);
      wr(2'd2, s[7:0]);
      repeat (per * 10 - 1) @(posedge clk_i);
      wr(2'd2, 8'h00);
      rd(2'd0, d);
      chk($sformatf("R3 rate cs=%0d", s), d, 8'd10);
    end

    // R7 flag waits for the tick; not set while stopped
    do_reset();
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h20);
    repeat (5) @(posedge clk_i);
    rd(2'd3, d);
    chk("R7 no flag while stopped", d, 8'h00);
    wr(2'd2, 8'h01);
    rd(2'd3, d);
    chk("R7 flag not yet set at equality", d, 8'h00);
    wr(2'd2, 8'h00);
    rd(2'd3, d);
    chk("R7 flag set after tick", d, 8'h02);
    rd(2'd0, d);
    chk("R7 count after two ticks", d, 8'h22);

    // R13 reads while stopped and while running
    rd(2'd1, d);
    chk("R13 compare readback", d, 8'h20);

    // R10 interrupt gating, R9 clear by acknowledge
    wr(2'd3, 8'h20);
    rd(2'd3, d);
    chk("R9 zero write keeps flag, R13 enable readback", d, 8'h22);
    gie_i = 1'b0;
    #1 chk("R10 irq blocked by gie", {7'd0, irq_cmp_o}, 8'h00);
    gie_i = 1'b1;
    #1 chk("R10 irq raised", {7'd0, irq_cmp_o}, 8'h01);
    wr(2'd3, 8'h00);
    #1 chk("R10 irq blocked by enable", {7'd0, irq_cmp_o}, 8'h00);
    @(negedge clk_i);
    cmp_ack_i = 1'b1;
    @(posedge clk_i);
    #1 cmp_ack_i = 1'b0;
    rd(2'd3, d);
    chk("R9 ack clears compare flag", d, 8'h00);

    // R9 overflow flag: write-one clear, ack clear
    wr(2'd0, 8'hFF);
    run_n(8'h01, 8'h00, 1);
    wr(2'd3, 8'h10);
    #1 chk("R10 ovf irq raised", {7'd0, irq_ovf_o}, 8'h01);
    wr(2'd3, 8'h11);
    rd(2'd3, d);
    chk("R9 write-one clears overflow", d, 8'h10);
    wr(2'd0, 8'hFF);
    run_n(8'h01, 8'h00, 1);
    @(negedge clk_i);
    ovf_ack_i = 1'b1;
    @(posedge clk_i);
    #1 ovf_ack_i = 1'b0;
    rd(2'd3, d);
    chk("R9 ack clears overflow", d, 8'h10);

    // R8 count write beats a tick; R13 control readback while running
    do_reset();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h40);
    rd(2'd0, d);
    chk("R8 write wins over tick", d, 8'h40);
    rd(2'd2, d);
    chk("R13 control read while running", d, 8'h01);
    rd(2'd0, d);
    chk("R13 count moves while running", d, 8'h42);
    wr(2'd2, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule